// File: doc/BRIEF.md
# Peripheral Debug Freeze Controller

This block drives one freeze line for each of eleven peripheral slots (timers, two watchdogs, DMA, USB and a PWM LED driver). A frozen peripheral stops counting or transferring until its line drops. Software owns a freeze state vector that it changes through two registers. Writing to one register sets bits, and writing to the other clears them, so no read-modify-write sequence is needed. The current state reads back at either address.

Debug halts add their own freezing on top of the software state. When the main core is halted and its freeze enable is high, every live slot freezes. The second core has its own enable that works the same way. The system watchdog slot follows two extra rules. It is always frozen while the main core is halted, whatever the enable says. Its software freeze only acts while the watchdog runs in interrupt mode rather than reset mode.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: After reset the software freeze state is all zero. With no halt active, every freeze output and every readback is zero.
- R2: A write to byte offset 0x0 sets each state bit whose data bit is 1 and leaves every bit written 0 unchanged. The slot bits are: 0 wake-up timer, 1 timer 1, 2 reserved, 3 system watchdog, 4 USB, 5 DMA, 6 timer 2, 7 PWM LED, 8 timer 3, 9 timer 4, 10 second core's watchdog.
- R3: A write to byte offset 0x4 clears each state bit whose data bit is 1 and leaves every bit written 0 unchanged.
- R4: A read at offset 0x0 or 0x4 returns the software freeze state in bits 10:0, with zeros above. A read at any other offset returns zero.
- R5: Bit 2 is reserved. It is never stored, always reads 0, and its freeze output is always 0.
- R6: While the main core is halted and its freeze enable is 1, all ten live freeze outputs are 1.
- R7: With the main-core freeze enable at 0, a main-core halt freezes only the system watchdog (bit 3). The other outputs follow the software state.
- R8: While the second core is halted and its enable is 1, all live outputs are 1. With that enable at 0, a halt of the second core has no effect.
- R9: With the watchdog mode input at 1 (reset mode), a software freeze of bit 3 is held in state but does not drive the output. Halt-based freezing of bit 3 is unaffected by the mode input.
- R10: A cycle without both select and write high, or a write to an offset other than 0x0 or 0x4, leaves the software state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| main_halted | input | 1 | Main core halted in debug |
| main_frz_en | input | 1 | Main-core halt freezes all slots |
| aux_halted | input | 1 | Second core halted |
| aux_frz_en | input | 1 | Second-core halt freezes all slots |
| wdog_rst_mode | input | 1 | 1: system watchdog in reset mode |
| freeze_o | output | 11 | Per-slot freeze lines |

## Verification
The software state changes at the clock edge that samples a write. Because both the freeze vector and the read data are combinational from that state, both show the new value in the cycle right after that edge. Changes on the halt, enable and mode inputs reach freeze_o in the same cycle with no register in between. The bench applies each stimulus a half cycle before an edge. It checks freeze_o 5 ns after that edge, then turns the access into a read and checks the read data 1 ns later, well before the next edge.

// File: rtl/dbg_freeze_ctrl.sv
`timescale 1ns/1ps
module dbg_freeze_ctrl #(
  parameter int NUM_SLOTS = 11,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int SET_OFS   = 0,
  parameter int CLR_OFS   = 4,
  parameter int WDOG_SLOT = 3,
  parameter int RSVD_SLOT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 main_halted,
  input  logic                 main_frz_en,
  input  logic                 aux_halted,
  input  logic                 aux_frz_en,
  input  logic                 wdog_rst_mode,
  output logic [NUM_SLOTS-1:0] freeze_o
);
  localparam logic [NUM_SLOTS-1:0] WDOG_BIT  = NUM_SLOTS'(1) << WDOG_SLOT;
  localparam logic [NUM_SLOTS-1:0] LIVE_MASK = {NUM_SLOTS{1'b1}} ^ (NUM_SLOTS'(1) << RSVD_SLOT);

  logic [NUM_SLOTS-1:0] sw_frz;

  wire hit_set = bus_addr == ADDR_W'(SET_OFS);
  wire hit_clr = bus_addr == ADDR_W'(CLR_OFS);
  wire wr_set  = bus_sel & bus_wr & hit_set;
  wire wr_clr  = bus_sel & bus_wr & hit_clr;
  wire [NUM_SLOTS-1:0] wmask = bus_wdata[NUM_SLOTS-1:0] & LIVE_MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sw_frz <= '0;
    else if (wr_set) sw_frz <= sw_frz | wmask;
    else if (wr_clr) sw_frz <= sw_frz & ~wmask;

  wire halt_all = (main_halted & main_frz_en) | (aux_halted & aux_frz_en);
  wire [NUM_SLOTS-1:0] sw_eff = sw_frz & ~(WDOG_BIT & {NUM_SLOTS{wdog_rst_mode}});

  assign freeze_o  = (sw_eff | {NUM_SLOTS{halt_all}} | (WDOG_BIT & {NUM_SLOTS{main_halted}})) & LIVE_MASK;
  assign bus_rdata = (bus_sel & (hit_set | hit_clr)) ? DATA_W'(sw_frz) : '0;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((sw_frz & ($past(bus_wdata[NUM_SLOTS-1:0]) & LIVE_MASK)) == ($past(bus_wdata[NUM_SLOTS-1:0]) & LIVE_MASK)));
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((sw_frz & $past(bus_wdata[NUM_SLOTS-1:0])) == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(sw_frz));
  p_main_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_halted && main_frz_en) |-> ((freeze_o & LIVE_MASK) == LIVE_MASK));
  p_wdog_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    main_halted |-> freeze_o[WDOG_SLOT]);
  p_sw_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_halted && !(aux_halted && aux_frz_en)) |-> ((freeze_o & ~WDOG_BIT) == (sw_frz & ~WDOG_BIT)));
  p_wdog_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_rst_mode && !main_halted && !(aux_halted && aux_frz_en)) |-> !freeze_o[WDOG_SLOT]);
endmodule

// File: tb/dbg_freeze_ctrl_test.sv
`timescale 1ns/1ps
module dbg_freeze_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic main_halted = 0, main_frz_en = 1, aux_halted = 0, aux_frz_en = 0, wdog_rst_mode = 0;
  logic [10:0] freeze_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dbg_freeze_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .main_halted(main_halted), .main_frz_en(main_frz_en), .aux_halted(aux_halted),
    .aux_frz_en(aux_frz_en), .wdog_rst_mode(wdog_rst_mode), .freeze_o(freeze_o));

  typedef struct packed {
    logic [1:0] op; logic [10:0] wd;
    logic mh, me, ah, ae, wm;
    logic [10:0] ef, er;
  } vec_t;
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 11'h021, 1'b0,1'b1,1'b0,1'b0,1'b0, 11'h021, 11'h021},
    '{2'd1, 11'h000, 1'b0,1'b1,1'b0,1'b0,1'b0, 11'h021, 11'h021},
    '{2'd1, 11'h7FF, 1'b0,1'b1,1'b0,1'b0,1'b0, 11'h7FB, 11'h7FB},
    '{2'd2, 11'h003, 1'b0,1'b1,1'b0,1'b0,1'b0, 11'h7F8, 11'h7F8},
    '{2'd2, 11'h000, 1'b0,1'b1,1'b0,1'b0,1'b0, 11'h7F8, 11'h7F8},
    '{2'd0, 11'h000, 1'b0,1'b1,1'b0,1'b0,1'b1, 11'h7F0, 11'h7F8},
    '{2'd2, 11'h7FF, 1'b0,1'b1,1'b0,1'b0,1'b0, 11'h000, 11'h000},
    '{2'd0, 11'h000, 1'b1,1'b1,1'b0,1'b0,1'b0, 11'h7FB, 11'h000},
    '{2'd0, 11'h000, 1'b1,1'b0,1'b0,1'b0,1'b0, 11'h008, 11'h000},
    '{2'd1, 11'h100, 1'b1,1'b0,1'b0,1'b0,1'b0, 11'h108, 11'h100},
    '{2'd0, 11'h000, 1'b0,1'b0,1'b1,1'b1,1'b0, 11'h7FB, 11'h100},
    '{2'd0, 11'h000, 1'b0,1'b0,1'b1,1'b0,1'b0, 11'h100, 11'h100},
    '{2'd0, 11'h000, 1'b0,1'b0,1'b1,1'b1,1'b1, 11'h7FB, 11'h100},
    '{2'd1, 11'h008, 1'b0,1'b0,1'b0,1'b0,1'b1, 11'h100, 11'h108},
    '{2'd0, 11'h000, 1'b0,1'b0,1'b0,1'b0,1'b0, 11'h108, 11'h108},
    '{2'd0, 11'h000, 1'b1,1'b0,1'b0,1'b0,1'b1, 11'h108, 11'h108}
  };
  localparam string VTAG [NV] = '{"R2","R2","R5","R3","R3","R9","R3","R6",
                                  "R7","R7","R8","R8","R9","R9","R9","R7"};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic wr, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #5;
    bus_wr = 0;
    #1;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    // R1: reset state
    access(0, 4'h0, '0);
    chk("R1", 32'(freeze_o), 32'h0);
    chk("R1", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      main_halted = VEC[i].mh; main_frz_en = VEC[i].me;
      aux_halted = VEC[i].ah; aux_frz_en = VEC[i].ae; wdog_rst_mode = VEC[i].wm;
      bus_sel = VEC[i].op != 0; bus_wr = VEC[i].op != 0;
      bus_addr = (VEC[i].op == 2) ? 4'h4 : 4'h0;
      bus_wdata = 32'(VEC[i].wd);
      @(posedge clk); #5;
      chk(VTAG[i], 32'(freeze_o), 32'(VEC[i].ef));
      bus_wr = 0; bus_sel = 1; bus_addr = 4'h0;
      #1;
      chk(VTAG[i], bus_rdata, 32'(VEC[i].er));
    end

    @(negedge clk);
    main_halted = 0; main_frz_en = 1; aux_halted = 0; aux_frz_en = 0; wdog_rst_mode = 0;
    // R4: readback at clear offset, zero at another offset
    access(0, 4'h4, '0);
    chk("R4", bus_rdata, 32'h108);
    access(0, 4'h8, '0);
    chk("R4", bus_rdata, 32'h0);
    // R10: select without write, and write to a foreign offset
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 4'h0; bus_wdata = 32'h7FF;
    @(posedge clk); #5;
    chk("R10", 32'(freeze_o), 32'h108);
    access(1, 4'h8, 32'h7FF);
    chk("R10", 32'(freeze_o), 32'h108);
    access(1, 4'hC, 32'h7FF);
    access(0, 4'h0, '0);
    chk("R10", bus_rdata, 32'h108);
    // R5: reserved bit written alone stays clear
    access(1, 4'h0, 32'h004);
    chk("R5", 32'(freeze_o), 32'h108);
    chk("R5", bus_rdata, 32'h108);
    // R1: reset mid-run clears state
    @(negedge clk); bus_sel = 0; rst_n = 0;
    #1; chk("R1", 32'(freeze_o), 32'h0);
    @(negedge clk); rst_n = 1;
    access(0, 4'h0, '0);
    chk("R1", bus_rdata, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule